// File: doc/BRIEF.md
# I2C Master Receive FIFO with Threshold Stall

This block is the receive-side byte store of an I2C master. The bit-level shifter hands over each received byte on a push port. The block keeps up to 32 bytes in order. A processor drains them by reading a data register. The software picks a fill level, called the threshold. When the occupancy climbs to that level, a sticky status flag is raised, and it can raise an interrupt. While the occupancy is at or above the threshold, the block asks the shifter to hold SCL low. This stops the remote slave from sending more data until software has drained bytes.

A LAST flag marks the current group of bytes as the final one. With LAST set, the byte that will bring the occupancy up to the threshold is answered with NACK instead of ACK. The flag then clears itself, so the next group defaults to ACK. When FIFO mode is disabled, the data register acts as a single-byte buffer. Other register controls empty the store and clear the sticky flags.

The register file has five 8-bit locations, selected by `reg_addr`:

| Address | Name | Fields |
|---|---|---|
| 0 | data | reading it pops one byte |
| 1 | control | bits 5:0 threshold, bit 6 interrupt enable, bit 7 LAST |
| 2 | status | bits 5:0 occupancy, bit 6 threshold flag (write 1 to clear), bit 7 overflow (write 1 to clear) |
| 3 | FIFO command | bit 1 full flag (write 1 to clear), bit 6 clear command (write 1, reads 0) |
| 4 | mode | bit 4 FIFO enable, reset value 0 |

Read data appears on `reg_rdata` one cycle after the read.

Top module: `i2c_rx_fifo_stall`

## Requirements
- R1: After synchronous reset the following all read 0: `rx_nack`, `scl_hold`, `irq`, `reg_rdata`, the occupancy and all flags. FIFO mode is off.
- R2: With FIFO mode on, up to 32 pushed bytes are kept. Reads of address 0 return them in push order. Status bits 5:0 give the occupancy.
- R3: A push that arrives when the store is at capacity is dropped. It sets the sticky overflow flag (status bit 7), which is cleared by writing 1 to that bit.
- R4: A read of address 0 while the store is empty returns 0xFF and leaves the occupancy unchanged.
- R5: The threshold flag (status bit 6) sets when a push raises the occupancy to equal a nonzero threshold (control bits 5:0). It stays set until 1 is written to that bit.
- R6: `irq` is high exactly when the threshold flag and the interrupt enable (control bit 6) are both set.
- R7: In FIFO mode, `scl_hold` is high while the threshold is nonzero and the occupancy is at or above it. A threshold of 0 never stalls. Popping below the threshold releases the stall.
- R8: With LAST (control bit 7) set, `rx_nack` is high while the occupancy is one below the threshold. Accepting the next byte clears LAST, and `rx_nack` then returns low.
- R9: Writing 1 to bit 6 of address 3 empties the store. That bit always reads 0.
- R10: The full flag (address 3 bit 1) sets when a push brings the occupancy to 32. It is cleared by writing 1 to that bit.
- R11: With FIFO mode off (address 4 bit 4 = 0), the capacity is one byte. `scl_hold` is high while that byte is held. The threshold flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Shifter presents a received byte |
| rx_byte | input | 8 | Received byte |
| rx_nack | output | 1 | Answer the next received byte with NACK |
| scl_hold | output | 1 | Request to hold SCL low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (address 0 pops) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Threshold interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the occupancy never exceeds the depth;
- a push at capacity always leaves overflow set;
- an empty pop never moves the occupancy;
- a clear always empties the store;
- an accepted NACKed byte always drops LAST;
- in single-byte mode, the stall only occurs while a byte is held.

Other behaviour can only be shown by the bench's scenarios. These are the push-to-pop data order, the 0xFF returned on an empty pop, the exact cycle the threshold flag and interrupt rise, the release of the stall after a drain, and the full-flag and single-byte behaviours seen through register reads.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned THR_W  = 6;

  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_STAT = 3'd2,
    SEL_FCS  = 3'd3,
    SEL_MODE = 3'd4
  } reg_sel_e;

  localparam int unsigned CTL_IE_BIT   = 6;
  localparam int unsigned CTL_LAST_BIT = 7;
  localparam int unsigned STS_THR_BIT  = 6;
  localparam int unsigned STS_OVF_BIT  = 7;
  localparam int unsigned FCS_FULL_BIT = 1;
  localparam int unsigned FCS_CLR_BIT  = 6;
  localparam int unsigned MODE_EN_BIT  = 4;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             ie;
    logic             last;
    logic             fifo_en;
  } rxq_cfg_t;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
// Byte array: one synchronous write port, asynchronous read (distributed RAM)
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
// Occupancy, pointers, sticky flags, stall and ACK/NACK decision
module rxq_ctrl #(
  parameter int DEPTH = 32,
  parameter int THR_W = 6,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop_req,
  input  logic             clr,
  input  logic [THR_W-1:0] thr,
  input  logic             last,
  input  logic             fifo_en,
  input  logic             w1c_thr,
  input  logic             w1c_ovf,
  input  logic             w1c_full,
  output logic [CNTW-1:0]  count,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    rd_ptr,
  output logic             we,
  output logic             empty,
  output logic             thst,
  output logic             ovf,
  output logic             full_flag,
  output logic             nack_next,
  output logic             nack_taken,
  output logic             hold
);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  int unsigned occ, lim, cap;
  logic        is_full, push_ok, pop_ok, reach;

  always_comb begin
    occ       = 32'(count);
    lim       = 32'(thr);
    cap       = fifo_en ? DEPTH : 1;
    is_full   = occ >= cap;
    empty     = (occ == 0);
    push_ok   = push && !is_full;
    pop_ok    = pop_req && !empty;
    reach     = fifo_en && (lim != 0) && (occ + 1 == lim);
    nack_next = last && reach;
    nack_taken = push_ok && nack_next && !clr;
    we        = push_ok && !clr;
    if (fifo_en) hold = (lim != 0) && (occ >= lim);
    else         hold = !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thst      <= 1'b0;
      ovf       <= 1'b0;
      full_flag <= 1'b0;
    end else begin
      if (push_ok && !pop_ok && !clr && reach) thst <= 1'b1;
      else if (w1c_thr)                        thst <= 1'b0;

      if (push && is_full && !clr) ovf <= 1'b1;
      else if (w1c_ovf)            ovf <= 1'b0;

      if (push_ok && !pop_ok && !clr && fifo_en && (occ + 1 == DEPTH)) full_flag <= 1'b1;
      else if (w1c_full)                                            full_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_regs.sv
`timescale 1ns/1ps
// Configuration registers, command decode and registered read mux
module rxq_regs
  import rxq_pkg::*;
#(
  parameter int CNTW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              nack_taken,
  input  logic [CNTW-1:0]   count,
  input  logic              empty,
  input  logic              thst,
  input  logic              ovf,
  input  logic              full_flag,
  input  logic [REG_DW-1:0] pop_data,
  output rxq_cfg_t          cfg,
  output logic              pop_req,
  output logic              clr,
  output logic              w1c_thr,
  output logic              w1c_ovf,
  output logic              w1c_full,
  output logic [REG_DW-1:0] reg_rdata
);
  reg_sel_e         sel;
  logic [THR_W-1:0] occ_field;

  assign sel       = reg_sel_e'(reg_addr);
  assign occ_field = THR_W'(count);
  assign pop_req   = reg_rd && (sel == SEL_DATA);
  assign clr       = reg_wr && (sel == SEL_FCS)  && reg_wdata[FCS_CLR_BIT];
  assign w1c_full  = reg_wr && (sel == SEL_FCS)  && reg_wdata[FCS_FULL_BIT];
  assign w1c_thr   = reg_wr && (sel == SEL_STAT) && reg_wdata[STS_THR_BIT];
  assign w1c_ovf   = reg_wr && (sel == SEL_STAT) && reg_wdata[STS_OVF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (reg_wr && sel == SEL_CTRL) begin
        cfg.thr  <= reg_wdata[THR_W-1:0];
        cfg.ie   <= reg_wdata[CTL_IE_BIT];
        cfg.last <= reg_wdata[CTL_LAST_BIT];
      end else if (nack_taken) begin
        cfg.last <= 1'b0;
      end
      if (reg_wr && sel == SEL_MODE) cfg.fifo_en <= reg_wdata[MODE_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_DATA: reg_rdata <= empty ? 8'hFF : pop_data;
        SEL_CTRL: reg_rdata <= {cfg.last, cfg.ie, cfg.thr};
        SEL_STAT: reg_rdata <= {ovf, thst, occ_field};
        SEL_FCS:  reg_rdata <= {6'b0, full_flag, 1'b0};
        SEL_MODE: reg_rdata <= {3'b0, cfg.fifo_en, 4'b0};
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rx_fifo_stall.sv
`timescale 1ns/1ps
module i2c_rx_fifo_stall
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_push,
  input  logic [REG_DW-1:0] rx_byte,
  output logic              rx_nack,
  output logic              scl_hold,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  rxq_cfg_t          cfg;
  logic [CNTW-1:0]   cnt;
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [REG_DW-1:0] head_byte;
  logic              we, empty, thst, ovf_flag, full_flag, nack_taken;
  logic              pop_req, clr_cmd, w1c_thr, w1c_ovf, w1c_full;

  rxq_store #(.DW(REG_DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (wr_ptr),
    .wdata (rx_byte),
    .raddr (rd_ptr),
    .rdata (head_byte)
  );

  rxq_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .push       (rx_push),
    .pop_req    (pop_req),
    .clr        (clr_cmd),
    .thr        (cfg.thr),
    .last       (cfg.last),
    .fifo_en    (cfg.fifo_en),
    .w1c_thr    (w1c_thr),
    .w1c_ovf    (w1c_ovf),
    .w1c_full   (w1c_full),
    .count      (cnt),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .we         (we),
    .empty      (empty),
    .thst       (thst),
    .ovf        (ovf_flag),
    .full_flag  (full_flag),
    .nack_next  (rx_nack),
    .nack_taken (nack_taken),
    .hold       (scl_hold)
  );

  rxq_regs #(.CNTW(CNTW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .nack_taken (nack_taken),
    .count      (cnt),
    .empty      (empty),
    .thst       (thst),
    .ovf        (ovf_flag),
    .full_flag  (full_flag),
    .pop_data   (head_byte),
    .cfg        (cfg),
    .pop_req    (pop_req),
    .clr        (clr_cmd),
    .w1c_thr    (w1c_thr),
    .w1c_ovf    (w1c_ovf),
    .w1c_full   (w1c_full),
    .reg_rdata  (reg_rdata)
  );

  assign irq = thst && cfg.ie;
endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
  parameter int DEPTH = 32,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_push,
  input logic            rx_nack,
  input logic            scl_hold,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [2:0]      reg_addr,
  input logic [CNTW-1:0] count,
  input logic            ovf,
  input logic            last,
  input logic            fifo_en,
  input logic            clr
);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_push && count == FULL_CNT && !clr) |=> ovf);

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd0 && count == '0 && !rx_push && !clr) |=> (count == '0));

  assert_last_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_nack && !clr && !(reg_wr && reg_addr == 3'd1)) |=> !last);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  assert_single_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (scl_hold && !fifo_en) |-> (count != '0));
endmodule

bind i2c_rx_fifo_stall rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_push  (rx_push),
  .rx_nack  (rx_nack),
  .scl_hold (scl_hold),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .count    (cnt),
  .ovf      (ovf_flag),
  .last     (cfg.last),
  .fifo_en  (cfg.fifo_en),
  .clr      (clr_cmd)
);

// File: tb/sim_i2c_rx_fifo_stall.sv
`timescale 1ns/1ps
module sim_i2c_rx_fifo_stall;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_push = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       rx_nack, scl_hold, irq;
  logic [7:0] reg_rdata;

  int   nchk = 0, nfail = 0;
  int   cap = 1;
  bit   done = 0;
  logic mon_arm = 1'b0;
  logic [7:0] mq[$];
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  i2c_rx_fifo_stall u0 (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_nack(rx_nack), .scl_hold(scl_hold), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    rx_push = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_push = 1'b0;
    if (mq.size() < cap) mq.push_back(b);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  // driver side of the scoreboard: predict the popped byte
  task automatic pop_byte();
    if (mq.size() > 0) exp_q.push_back(mq.pop_front());
    else               exp_q.push_back(8'hFF);
    rd_reg(3'd0);
  endtask

  // monitor side: compare popped bytes as they appear
  always @(posedge clk) mon_arm <= reg_rd && (reg_addr == 3'd0) && !rst;
  always @(negedge clk) begin
    if (mon_arm && exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      if (e == 8'hFF) chk("R4 empty pop value", reg_rdata, e);
      else            chk("R2 pop order", reg_rdata, e);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 rx_nack", {7'b0, rx_nack}, 8'h00);
    chk("R1 scl_hold", {7'b0, scl_hold}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd_reg(3'd2); chk("R1 status", reg_rdata, 8'h00);

    // R11 single-byte mode
    cap = 1;
    wr_reg(3'd1, 8'h01);
    push_byte(8'hA5);
    chk("R11 hold while held", {7'b0, scl_hold}, 8'h01);
    rd_reg(3'd2); chk("R11 no thr flag", reg_rdata, 8'h01);
    push_byte(8'h3C);
    rd_reg(3'd2); chk("R3 ovf single", reg_rdata, 8'h81);
    pop_byte();
    chk("R11 release", {7'b0, scl_hold}, 8'h00);
    wr_reg(3'd2, 8'h80);
    rd_reg(3'd2); chk("R3 ovf w1c", reg_rdata, 8'h00);

    // R5 R6 R7 threshold in FIFO mode
    wr_reg(3'd4, 8'h10); cap = 32;
    rd_reg(3'd4); chk("R2 mode readback", reg_rdata, 8'h10);
    wr_reg(3'd1, 8'h44);
    for (int i = 0; i < 3; i++) push_byte(8'h10 + 8'(i));
    chk("R7 below thr", {7'b0, scl_hold}, 8'h00);
    chk("R6 irq low", {7'b0, irq}, 8'h00);
    push_byte(8'h13);
    chk("R7 at thr", {7'b0, scl_hold}, 8'h01);
    chk("R6 irq high", {7'b0, irq}, 8'h01);
    rd_reg(3'd2); chk("R5 flag and count", reg_rdata, 8'h44);
    pop_byte();
    chk("R7 released", {7'b0, scl_hold}, 8'h00);
    chk("R5 sticky", {7'b0, irq}, 8'h01);
    wr_reg(3'd2, 8'h40);
    chk("R6 irq after w1c", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 3; i++) pop_byte();

    // R8 LAST group
    wr_reg(3'd1, 8'h83);
    chk("R8 no nack at 0", {7'b0, rx_nack}, 8'h00);
    push_byte(8'h21); push_byte(8'h22);
    chk("R8 nack armed", {7'b0, rx_nack}, 8'h01);
    push_byte(8'h23);
    chk("R8 nack gone", {7'b0, rx_nack}, 8'h00);
    rd_reg(3'd1); chk("R8 last cleared", reg_rdata, 8'h03);
    for (int i = 0; i < 3; i++) pop_byte();
    wr_reg(3'd2, 8'h40);

    // R2 R3 R10 full depth
    wr_reg(3'd1, 8'h00);
    for (int i = 0; i < 32; i++) push_byte(8'(i * 7 + 1));
    rd_reg(3'd2); chk("R2 occupancy 32", reg_rdata, 8'h20);
    chk("R7 thr zero no stall", {7'b0, scl_hold}, 8'h00);
    rd_reg(3'd3); chk("R10 full flag", reg_rdata, 8'h02);
    push_byte(8'hEE);
    rd_reg(3'd2); chk("R3 ovf at full", reg_rdata, 8'hA0);
    wr_reg(3'd3, 8'h02);
    rd_reg(3'd3); chk("R10 full w1c", reg_rdata, 8'h00);
    wr_reg(3'd2, 8'h80);
    for (int i = 0; i < 32; i++) pop_byte();
    pop_byte();
    rd_reg(3'd2); chk("R4 count stays 0", reg_rdata, 8'h00);

    // R9 clear command
    for (int i = 0; i < 5; i++) push_byte(8'h50 + 8'(i));
    wr_reg(3'd3, 8'h40); mq.delete();
    rd_reg(3'd2); chk("R9 emptied", reg_rdata, 8'h00);
    rd_reg(3'd3); chk("R9 clr reads 0", reg_rdata, 8'h00);
    pop_byte();
    @(negedge clk); #1;

    chk("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    summary();
    $finish;
  end
endmodule